// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block connects a 16-bit register bus to an 8-bit NAND flash device. Software selects how the NAND control pins behave through one byte-wide mode register: chip enable, command latch, address latch, the write gate and card power each take one bit of it. Every access to the data register turns into NAND bus cycles. In data mode a 16-bit word becomes two byte cycles, low byte first. In command or address mode only the low byte is sent, in a single cycle. The host is held off through a ready handshake until those cycles are over.

The ready/busy line from the device passes through a two-flop synchronizer. Its synchronized level appears as a busy flag in a status register. Its rising edge, when the device finishes an operation, latches an event bit. That bit stays set until software clears it by writing a one to it. A mask register decides whether the latched event drives the interrupt output. The intended use is to start a long program or erase, enable the mask, and wait for the interrupt.

A sequencer state machine runs the host transaction. In SQ_IDLE a request is decoded. A register access or a gated-off data access goes straight to SQ_ACK. A data access that is allowed goes to SQ_SETUP, where the byte is placed on the bus with the strobe high. Then comes SQ_STROBE, where WE# or RE# is held low for a fixed number of clocks, and then SQ_HOLD, where the strobe is high again and write data is still driven. From SQ_HOLD the machine returns to SQ_SETUP for the second byte, or moves on to SQ_ACK after the last one. SQ_ACK pulses the host ready and returns to SQ_IDLE.

Top module: `nand_bridge`

## Requirements
- R1: After reset, nand_ce_n=1, nand_cle=0, nand_ale=0, nand_we_n=1, nand_re_n=1, irq=0, card_pwr=0, host_ready=0, and the mode, event and mask registers read 0.
- R2: The register offsets on host_addr are: data 0, mode 4, status 5, event 6, mask 7. A register read returns its byte in host_rdata[7:0] with host_rdata[15:8]=0. Offsets 1 to 3 read 0. A write stores only host_wdata[7:0].
- R3: Mode bit 4 set drives nand_ce_n low, bit 1 drives nand_ale, bit 0 drives nand_cle and bit 2 drives card_pwr. So 0x94 is data mode, 0x95 command mode, 0x96 address mode, 0x00 standby, and 0x0C/0x08 switch card power on/off.
- R4: In data mode, a write to the data register issues two WE# cycles: host_wdata[7:0] goes out first and host_wdata[15:8] second, with nand_cle=0 and nand_ale=0.
- R5: When mode bit 0 or bit 1 is set, a data register access issues exactly one NAND cycle. For a write, only host_wdata[7:0] is driven. For a read, host_rdata[15:8]=0.
- R6: In data mode, a read of the data register issues two RE# cycles. The first byte returns in host_rdata[7:0] and the second in host_rdata[15:8].
- R7: Each WE# or RE# strobe stays low for exactly STROBE_CLKS clocks, and the two are never low together. Write data is driven through the clock in which WE# rises, and nand_dq_oe is low while RE# is low.
- R8: host_ready is a one-cycle pulse. With the request first seen at clock edge 1, ready appears after edge 1 for a register access, after edge STROBE_CLKS+3 for a one-byte data access, and after edge 2*STROBE_CLKS+5 for a two-byte data access.
- R9: A data register access with mode bit 4 clear, or a data write with mode bit 7 clear, issues no NAND cycle. It is still acknowledged after edge 1, and a read of this kind returns 0.
- R10: Status bit 7 reads 1 while nand_rb is low (busy) and 0 when it is high. The other status bits read 0.
- R11: A rising edge of the synchronized nand_rb sets event bit 0. The bit stays set until a write to offset 6 with wdata bit 0 set, and writing 0 to it has no effect. Writing 0x0F clears all event bits.
- R12: irq = mask bit 7 AND (OR over event[3:0] AND mask[3:0]). So writing 0x81 to the mask enables the ready interrupt and writing 0x00 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_ready |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_dq_out | output | 8 | NAND data out |
| nand_dq_oe | output | 1 | NAND data output enable |
| nand_dq_in | input | 8 | NAND data in |
| nand_rb | input | 1 | NAND ready (1) / busy (0) |
| card_pwr | output | 1 | Card power switch control |
| irq | output | 1 | Ready interrupt |

## Verification
The properties assume that the host keeps host_req, host_wr, host_addr and host_wdata steady until it sees host_ready, and drops the request in the cycle that shows ready. They also assume that the mode register is written only between transactions, which holds because register writes are accepted only in SQ_IDLE. The stimulus drives every input half a cycle away from the active edge and keeps each request open until the ready pulse. Changes on nand_rb are spaced several clocks apart so that every level passes through the synchronizer. nand_dq_in changes only after an RE# rising edge, so it is stable during each strobe.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
    localparam int HOST_AW = 3;

    localparam logic [HOST_AW-1:0] OFF_DATA = 3'd0;
    localparam logic [HOST_AW-1:0] OFF_MODE = 3'd4;
    localparam logic [HOST_AW-1:0] OFF_STAT = 3'd5;
    localparam logic [HOST_AW-1:0] OFF_EVT  = 3'd6;
    localparam logic [HOST_AW-1:0] OFF_MASK = 3'd7;

    localparam int MB_CLE = 0;
    localparam int MB_ALE = 1;
    localparam int MB_PWR = 2;
    localparam int MB_CE  = 4;
    localparam int MB_WEN = 7;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD,
        SQ_ACK
    } seq_state_e;
endpackage

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs
    import nand_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rd_byte,
    input  logic               nand_rb,
    output logic               ce_on,
    output logic               cle,
    output logic               ale,
    output logic               wgate,
    output logic               card_pwr,
    output logic               irq
);
    logic [7:0] mode_q;
    logic [7:0] mask_q;
    logic [3:0] evt_q;
    logic [1:0] rb_sync_q;
    logic       rb_prev_q;
    logic       rb_rise;
    logic [3:0] evt_clr;

    assign rb_rise = rb_sync_q[1] & ~rb_prev_q;
    assign evt_clr = (wr_en && addr == OFF_EVT) ? wdata[3:0] : 4'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 8'd0;
            mask_q    <= 8'd0;
            evt_q     <= 4'd0;
            rb_sync_q <= 2'b11;
            rb_prev_q <= 1'b1;
        end else begin
            rb_sync_q <= {rb_sync_q[0], nand_rb};
            rb_prev_q <= rb_sync_q[1];
            if (wr_en && addr == OFF_MODE) mode_q <= wdata;
            if (wr_en && addr == OFF_MASK) mask_q <= wdata;
            // a new event wins over a clear in the same cycle
            evt_q <= (evt_q & ~evt_clr) | {3'b000, rb_rise};
        end
    end

    always_comb begin
        ce_on    = mode_q[MB_CE];
        cle      = mode_q[MB_CLE];
        ale      = mode_q[MB_ALE];
        wgate    = mode_q[MB_WEN];
        card_pwr = mode_q[MB_PWR];
        irq      = mask_q[7] & |(evt_q & mask_q[3:0]);
    end

    always_comb begin
        case (addr)
            OFF_MODE: rd_byte = mode_q;
            OFF_STAT: rd_byte = {~rb_sync_q[1], 7'd0};
            OFF_EVT:  rd_byte = {4'd0, evt_q};
            OFF_MASK: rd_byte = mask_q;
            default:  rd_byte = 8'd0;
        endcase
    end

    // R11: a ready edge is captured one clock later
    a_r11_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        rb_rise |=> evt_q[0]);

    // R11: the event bit is sticky until a write-one clear
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[0] && !(wr_en && addr == OFF_EVT && wdata[0])) |=> evt_q[0]);
endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
    import nand_bridge_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [15:0]        host_wdata,
    output logic               host_ready,
    output logic [15:0]        host_rdata,
    input  logic [7:0]         reg_rdata,
    output logic               reg_we,
    input  logic               ce_on,
    input  logic               wgate,
    input  logic               single_cycle,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [7:0]         nand_dq_out,
    output logic               nand_dq_oe,
    input  logic [7:0]         nand_dq_in
);
    localparam int CNT_W = $clog2(STROBE_CLKS + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    seq_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lowcnt_q;
    logic            byte_q;
    logic            last_q;
    logic            is_wr_q;
    logic [15:0]     wdata_q;
    logic [15:0]     rdata_q;
    logic            data_hit;
    logic            strobe_low;

    assign data_hit = (host_addr == OFF_DATA) && ce_on && (!host_wr || wgate);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (host_req) state_d = data_hit ? SQ_SETUP : SQ_ACK;
            SQ_SETUP:  state_d = SQ_STROBE;
            SQ_STROBE: if (cnt_q == CNT_LAST) state_d = SQ_HOLD;
            SQ_HOLD:   state_d = (byte_q == last_q) ? SQ_ACK : SQ_SETUP;
            SQ_ACK:    state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            byte_q  <= 1'b0;
            last_q  <= 1'b0;
            is_wr_q <= 1'b0;
            wdata_q <= 16'd0;
            rdata_q <= 16'd0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                SQ_IDLE: begin
                    if (host_req) begin
                        if (data_hit) begin
                            byte_q  <= 1'b0;
                            last_q  <= ~single_cycle;
                            is_wr_q <= host_wr;
                            wdata_q <= host_wdata;
                            rdata_q <= 16'd0;
                        end else begin
                            is_wr_q <= 1'b0;
                            rdata_q <= (host_wr || host_addr == OFF_DATA) ?
                                       16'd0 : {8'd0, reg_rdata};
                        end
                    end
                end
                SQ_SETUP: cnt_q <= '0;
                SQ_STROBE: begin
                    if (cnt_q == CNT_LAST) begin
                        if (!is_wr_q) begin
                            if (byte_q) rdata_q[15:8] <= nand_dq_in;
                            else        rdata_q[7:0]  <= nand_dq_in;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_HOLD: if (byte_q != last_q) byte_q <= 1'b1;
                SQ_ACK:  is_wr_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        reg_we      = (state_q == SQ_IDLE) && host_req && host_wr && (host_addr != OFF_DATA);
        host_ready  = (state_q == SQ_ACK);
        host_rdata  = rdata_q;
        nand_we_n   = !((state_q == SQ_STROBE) && is_wr_q);
        nand_re_n   = !((state_q == SQ_STROBE) && !is_wr_q);
        nand_dq_oe  = is_wr_q && ((state_q == SQ_SETUP) || (state_q == SQ_STROBE) ||
                                  (state_q == SQ_HOLD));
        nand_dq_out = byte_q ? wdata_q[15:8] : wdata_q[7:0];
    end

    // checker bookkeeping: consecutive clocks with a strobe low
    assign strobe_low = !nand_we_n || !nand_re_n;
    always_ff @(posedge clk) begin
        if (!rst_n)          lowcnt_q <= '0;
        else if (strobe_low) lowcnt_q <= lowcnt_q + 1'b1;
        else                 lowcnt_q <= '0;
    end

    // R7: every strobe pulse lasts exactly STROBE_CLKS clocks
    a_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_low) |-> ($past(lowcnt_q) == CNT_LAST));

    a_r7_strobe_cap: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> (lowcnt_q <= CNT_LAST));

    // R7: write and read strobes never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R7: data still driven in the clock WE# rises
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> nand_dq_oe);

    // R7: bridge never drives the bus during a read strobe
    a_r7_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    // R8: completion is a single-cycle pulse
    a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R9: no strobes while chip enable is released
    a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_on |-> (nand_we_n && nand_re_n));
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
    import nand_bridge_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [15:0]        host_wdata,
    output logic               host_ready,
    output logic [15:0]        host_rdata,
    output logic               nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [7:0]         nand_dq_out,
    output logic               nand_dq_oe,
    input  logic [7:0]         nand_dq_in,
    input  logic               nand_rb,
    output logic               card_pwr,
    output logic               irq
);
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       ce_on;
    logic       wgate;

    nand_bridge_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .addr     (host_addr),
        .wdata    (host_wdata[7:0]),
        .rd_byte  (reg_rdata),
        .nand_rb  (nand_rb),
        .ce_on    (ce_on),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .wgate    (wgate),
        .card_pwr (card_pwr),
        .irq      (irq)
    );

    nand_bridge_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_ready   (host_ready),
        .host_rdata   (host_rdata),
        .reg_rdata    (reg_rdata),
        .reg_we       (reg_we),
        .ce_on        (ce_on),
        .wgate        (wgate),
        .single_cycle (nand_cle | nand_ale),
        .nand_we_n    (nand_we_n),
        .nand_re_n    (nand_re_n),
        .nand_dq_out  (nand_dq_out),
        .nand_dq_oe   (nand_dq_oe),
        .nand_dq_in   (nand_dq_in)
    );

    assign nand_ce_n = ~ce_on;
endmodule

// File: tb/nand_bridge_test.sv
module nand_bridge_test;
    localparam int STROBE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'd0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_out;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_in;
    logic        nand_rb = 1'b1;
    logic        card_pwr, irq;

    always #2 clk = ~clk;

    nand_bridge #(.STROBE_CLKS(STROBE)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb), .card_pwr(card_pwr), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // NAND device model: byte log on WE# rise, counting data source for reads
    logic [9:0] wlog [64];
    int         wcount = 0;
    logic [7:0] rd_idx = 8'd0;
    logic       we_prev = 1'b1, re_prev = 1'b1;
    int         low_run = 0;

    assign nand_dq_in = 8'h5A + rd_idx;

    always @(posedge clk) begin
        if (!we_prev && nand_we_n) begin
            wlog[wcount[5:0]] <= {nand_cle, nand_ale, nand_dq_out};
            wcount <= wcount + 1;
        end
        if (!re_prev && nand_re_n) rd_idx <= rd_idx + 8'd1;
        if (!nand_we_n || !nand_re_n) low_run <= low_run + 1;
        else begin
            if (low_run != 0) check(low_run == STROBE, "R7 strobe width", low_run, STROBE);
            low_run <= 0;
        end
        if (!nand_we_n && !nand_re_n) check(1'b0, "R7 strobe overlap", 1, 0);
        we_prev <= nand_we_n;
        re_prev <= nand_re_n;
    end

    int          lat;
    logic [15:0] rd;

    task automatic bus(input bit wr, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ready && lat < 200);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    // {wr, addr, wdata, expected read}
    localparam logic [35:0] VEC [10] = '{
        {1'b1, 3'd4, 16'h5596, 16'h0000},
        {1'b0, 3'd4, 16'h0000, 16'h0096},
        {1'b1, 3'd4, 16'h0094, 16'h0000},
        {1'b0, 3'd4, 16'h0000, 16'h0094},
        {1'b1, 3'd7, 16'h0081, 16'h0000},
        {1'b0, 3'd7, 16'h0000, 16'h0081},
        {1'b0, 3'd5, 16'h0000, 16'h0000},
        {1'b0, 3'd1, 16'h0000, 16'h0000},
        {1'b1, 3'd7, 16'h0000, 16'h0000},
        {1'b0, 3'd6, 16'h0000, 16'h0000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        // R1 reset outputs
        check({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, irq, card_pwr, host_ready}
              == 8'b10011000, "R1 reset pins",
              {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, irq, card_pwr, host_ready},
              8'b10011000);
        rst_n = 1'b1;
        bus(0, 3'd4, 0); check(rd == 16'h0, "R1 mode reset", rd, 0);
        bus(0, 3'd6, 0); check(rd == 16'h0, "R1 event reset", rd, 0);
        bus(0, 3'd7, 0); check(rd == 16'h0, "R1 mask reset", rd, 0);
        check(lat == 1, "R8 register latency", lat, 1);

        // R2 table walk
        for (int i = 0; i < 10; i++) begin
            bus(VEC[i][35], VEC[i][34:32], VEC[i][31:16]);
            if (!VEC[i][35]) check(rd == VEC[i][15:0], "R2 register map", rd, VEC[i][15:0]);
        end

        // R3 data mode pins, R4 two-byte write
        bus(1, 3'd4, 16'h0094);
        check({nand_ce_n, nand_cle, nand_ale, card_pwr} == 4'b0001, "R3 data mode pins",
              {nand_ce_n, nand_cle, nand_ale, card_pwr}, 4'b0001);
        base = wcount;
        bus(1, 3'd0, 16'hBEEF);
        check(lat == 2 * STROBE + 5, "R8 two-byte latency", lat, 2 * STROBE + 5);
        @(negedge clk);
        check(wcount == base + 2, "R4 byte count", wcount - base, 2);
        check(wlog[base[5:0]] == 10'h0EF, "R4 first byte low", wlog[base[5:0]], 10'h0EF);
        check(wlog[base[5:0] + 6'd1] == 10'h0BE, "R4 second byte high", wlog[base[5:0] + 6'd1], 10'h0BE);

        // R5 command mode single cycle
        bus(1, 3'd4, 16'h0095);
        check(nand_cle == 1'b1 && nand_ale == 1'b0, "R3 command mode", {nand_cle, nand_ale}, 2'b10);
        base = wcount;
        bus(1, 3'd0, 16'h1270);
        check(lat == STROBE + 3, "R8 one-byte latency", lat, STROBE + 3);
        @(negedge clk);
        check(wcount == base + 1, "R5 command one cycle", wcount - base, 1);
        check(wlog[base[5:0]] == 10'h270, "R5 command byte", wlog[base[5:0]], 10'h270);

        // R5 address mode
        bus(1, 3'd4, 16'h0096);
        check(nand_ale == 1'b1 && nand_cle == 1'b0, "R3 address mode", {nand_cle, nand_ale}, 2'b01);
        base = wcount;
        bus(1, 3'd0, 16'h3344);
        @(negedge clk);
        check(wcount == base + 1, "R5 address one cycle", wcount - base, 1);
        check(wlog[base[5:0]] == 10'h144, "R5 address byte", wlog[base[5:0]], 10'h144);

        // R6 two-byte read
        bus(1, 3'd4, 16'h0094);
        bus(0, 3'd0, 0);
        check(rd == 16'h5B5A, "R6 read order", rd, 16'h5B5A);
        // R5 single read in command mode
        bus(1, 3'd4, 16'h0095);
        bus(0, 3'd0, 0);
        check(rd == 16'h005C, "R5 single read", rd, 16'h005C);

        // R9 standby: no cycles, immediate ack, read zero
        bus(1, 3'd4, 16'h0000);
        check(nand_ce_n == 1'b1 && card_pwr == 1'b0, "R3 standby", {nand_ce_n, card_pwr}, 2'b10);
        base = wcount;
        bus(1, 3'd0, 16'hAAAA);
        check(lat == 1, "R9 standby write ack", lat, 1);
        bus(0, 3'd0, 0);
        check(rd == 16'h0, "R9 standby read", rd, 0);
        @(negedge clk);
        check(wcount == base && rd_idx == 8'd3, "R9 standby no cycles", wcount - base, 0);
        // R9 write gate clear
        bus(1, 3'd4, 16'h0014);
        bus(1, 3'd0, 16'h7777);
        @(negedge clk);
        check(wcount == base, "R9 gated write", wcount - base, 0);
        bus(0, 3'd0, 0);
        check(rd == 16'h5E5D, "R9 gated mode still reads", rd, 16'h5E5D);

        // R3 power
        bus(1, 3'd4, 16'h000C);
        check(card_pwr == 1'b1, "R3 power on", card_pwr, 1);
        bus(1, 3'd4, 16'h0008);
        check(card_pwr == 1'b0, "R3 power off", card_pwr, 0);

        // R10 busy flag
        nand_rb = 1'b0;
        repeat (5) @(negedge clk);
        bus(0, 3'd5, 0);
        check(rd == 16'h0080, "R10 busy", rd, 16'h0080);
        // R11/R12 event and interrupt
        bus(1, 3'd7, 16'h0081);
        bus(1, 3'd6, 16'h000F);
        check(irq == 1'b0, "R12 no event yet", irq, 0);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R12 irq on ready edge", irq, 1);
        bus(0, 3'd5, 0);
        check(rd == 16'h0000, "R10 ready", rd, 0);
        bus(0, 3'd6, 0);
        check(rd == 16'h0001, "R11 event latched", rd, 1);
        bus(1, 3'd6, 16'h0000);
        bus(0, 3'd6, 0);
        check(rd == 16'h0001, "R11 zero write no effect", rd, 1);
        bus(1, 3'd6, 16'h000F);
        bus(0, 3'd6, 0);
        check(rd == 16'h0000, "R11 cleared", rd, 0);
        check(irq == 1'b0, "R12 irq after clear", irq, 0);

        // R12 mask disabled
        bus(1, 3'd7, 16'h0000);
        nand_rb = 1'b0; repeat (5) @(negedge clk);
        nand_rb = 1'b1; repeat (5) @(negedge clk);
        check(irq == 1'b0, "R12 masked", irq, 0);
        bus(0, 3'd6, 0);
        check(rd == 16'h0001, "R11 event while masked", rd, 1);
        bus(1, 3'd7, 16'h0001);
        check(irq == 1'b0, "R12 master bit clear", irq, 0);
        bus(1, 3'd7, 16'h0081);
        check(irq == 1'b1, "R12 enabled pending", irq, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule